// File: doc/BRIEF.md
# SCL Clock Phase Generator

This block produces the serial clock timing for the master side of a two-wire serial bus. From a 12-bit clock-control value it derives the length of the low phase and the high phase of SCL, counted in peripheral-clock cycles. It drives an open-drain style pull-low request and releases the line at the end of each low phase. The high phase begins only once the returning line is seen high through a synchronizer, so a slave that holds SCL low stretches the clock.

Three duty ratios come from the one control value. Standard mode splits the period evenly. Fast mode gives a low:high ratio of 2:1 by default and 16:9 when the duty bit is set. Values below the legal floor for the selected mode are raised to that floor, so no phase ever has zero length. The byte engine receives a one-cycle strobe at each phase boundary. As an example of scale, a control value of 0x28 in standard mode on an 8 MHz peripheral clock gives 100 kHz.

Top module: `sclgen_top`

## Requirements
- R1: While `enable_i` is low, `scl_low_o`, `rise_stb_o` and `fall_stb_o` are all 0, including directly after reset.
- R2: In standard mode (`ccr_hi_i[7]`=0) the high phase and the low phase each last C cycles, where C is the effective control value.
- R3: In fast mode with duty bit clear (`ccr_hi_i[7]`=1, `ccr_hi_i[6]`=0) the high phase lasts C cycles and the low phase 2*C cycles.
- R4: In fast mode with duty bit set (`ccr_hi_i[7]`=1, `ccr_hi_i[6]`=1) the high phase lasts 9*C cycles and the low phase 16*C cycles.
- R5: In standard mode and in fast mode with duty clear, a raw control value below 4 acts as 4.
- R6: In fast mode with duty set, a raw control value of 0 acts as 1; values of 1 and above are used as given.
- R7: After `scl_low_o` falls, `rise_stb_o` appears exactly K+SYNC_STAGES+1 cycles later, where K is the number of cycles `scl_line_i` is still held low by another device; no high phase is counted while the line reads low.
- R8: `rise_stb_o` and `fall_stb_o` are single-cycle pulses that never coincide; `fall_stb_o` marks the first cycle of `scl_low_o`, and the high phase is measured from `rise_stb_o` to `fall_stb_o`.
- R9: Dropping `enable_i` during a phase releases `scl_low_o` on the next cycle; on re-enable with the line high, the first strobe is `rise_stb_o`, two cycles after `enable_i` rises.
- R10: The raw control value is {`ccr_hi_i[3:0]`, `ccr_lo_i[7:0]`}; `ccr_hi_i[5:4]` have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Runs the generator; low releases SCL |
| ccr_lo_i | input | 8 | Control value bits 7:0 |
| ccr_hi_i | input | 8 | Bit 7 fast select, bit 6 duty, bits 3:0 control value bits 11:8 |
| scl_line_i | input | 1 | Sampled SCL line level |
| scl_low_o | output | 1 | 1 requests SCL pulled low |
| rise_stb_o | output | 1 | One-cycle pulse at start of high phase |
| fall_stb_o | output | 1 | One-cycle pulse at start of low phase |

## Verification
A wrong phase count or a wrongly scaled control value shows within one SCL period as a high or low length that differs from the arithmetic of the selected mode, so sweeping every small control value in all three modes exposes it after one period each. A wrong floor shows at the smallest values, where the measured length stays constant instead of tracking the input. A broken hold-off or synchronizer shows as a rise strobe arriving too early or too late relative to the line release, within a few cycles of the release.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  localparam int CCR_W = 12;
  localparam int LEN_W = CCR_W + 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;

  // Smallest legal control value for the selected mode.
  function automatic logic [CCR_W-1:0] ccr_floor(input logic fast, input logic duty);
    return (fast && duty) ? CCR_W'(1) : CCR_W'(4);
  endfunction

  function automatic logic [CCR_W-1:0] ccr_clamp(input logic [CCR_W-1:0] raw,
                                                 input logic fast, input logic duty);
    logic [CCR_W-1:0] fl;
    fl = ccr_floor(fast, duty);
    return (raw < fl) ? fl : raw;
  endfunction

  function automatic logic [4:0] high_mult(input logic fast, input logic duty);
    return (fast && duty) ? 5'd9 : 5'd1;
  endfunction

  function automatic logic [4:0] low_mult(input logic fast, input logic duty);
    if (!fast) return 5'd1;
    return duty ? 5'd16 : 5'd2;
  endfunction

  function automatic logic [LEN_W-1:0] scale(input logic [CCR_W-1:0] c, input logic [4:0] m);
    logic [LEN_W-1:0] p;
    p = LEN_W'(c) * LEN_W'(m);
    return p;
  endfunction

endpackage

// File: rtl/sclgen_phase_calc.sv
module sclgen_phase_calc
  import sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ccr_lo_i,
  input  logic [7:0]       ccr_hi_i,
  output logic [LEN_W-1:0] hi_len_o,
  output logic [LEN_W-1:0] lo_len_o
);

  logic             fast_sel;
  logic             duty_sel;
  logic [CCR_W-1:0] raw_ccr;
  logic [CCR_W-1:0] eff_ccr;
  logic [1:0]       cfg_unused;

  assign fast_sel   = ccr_hi_i[7];
  assign duty_sel   = ccr_hi_i[6];
  assign cfg_unused = ccr_hi_i[5:4];
  assign raw_ccr    = {ccr_hi_i[CCR_W-9:0], ccr_lo_i};
  assign eff_ccr    = ccr_clamp(raw_ccr, fast_sel, duty_sel);

  assign hi_len_o = scale(eff_ccr, high_mult(fast_sel, duty_sel));
  assign lo_len_o = scale(eff_ccr, low_mult(fast_sel, duty_sel));

  // R2: even split in standard mode
  p_even_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_sel |-> (lo_len_o == hi_len_o));
  // R3: low twice high in fast mode, duty clear
  p_two_to_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_sel && !duty_sel) |-> (lo_len_o == {hi_len_o[LEN_W-2:0], 1'b0}));
  // R4: 16:9 in fast mode, duty set
  p_sixteen_nine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_sel && duty_sel) |-> (int'(hi_len_o) * 16 == int'(lo_len_o) * 9));
  // R5: floor of four outside the 16:9 mode
  p_floor_four_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_sel && duty_sel) |-> (hi_len_o >= LEN_W'(4) && lo_len_o >= LEN_W'(4)));
  // R6: never a zero-length phase
  p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len_o != '0) && (lo_len_o != '0));

endmodule

// File: rtl/sclgen_line_sync.sv
module sclgen_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_hi_o
);

  generate
    if (STAGES == 0) begin : g_direct
      assign line_hi_o = line_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else if (STAGES == 1) chain_q <= line_i;
        else chain_q <= {chain_q[STAGES-2:0], line_i};
      end
      assign line_hi_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
  import sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             line_hi_i,
  input  logic [LEN_W-1:0] hi_len_i,
  input  logic [LEN_W-1:0] lo_len_i,
  output logic             scl_low_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);

  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic             cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      rise_stb_o <= 1'b0;
      fall_stb_o <= 1'b0;
    end else begin
      rise_stb_o <= 1'b0;
      fall_stb_o <= 1'b0;
      if (!enable_i) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_IDLE: phase_q <= PH_WAIT;
          PH_WAIT: begin
            if (line_hi_i) begin
              phase_q    <= PH_HIGH;
              cnt_q      <= hi_len_i - LEN_W'(1);
              rise_stb_o <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt_done) begin
              phase_q    <= PH_LOW;
              cnt_q      <= lo_len_i - LEN_W'(1);
              fall_stb_o <= 1'b1;
            end else begin
              cnt_q <= cnt_q - LEN_W'(1);
            end
          end
          PH_LOW: begin
            if (cnt_done) phase_q <= PH_WAIT;
            else cnt_q <= cnt_q - LEN_W'(1);
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign scl_low_o = (phase_q == PH_LOW);

  // R1 / R9: disable releases the line on the next cycle
  p_disable_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!scl_low_o && !rise_stb_o && !fall_stb_o));
  // R7: a high phase starts only after the synchronized line read high
  p_rise_after_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |-> $past(line_hi_i));
  // R8: strobes never coincide
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb_o && fall_stb_o));
  // R8: fall strobe marks the first pulled-low cycle
  p_fall_marks_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb_o |-> (scl_low_o && !$past(scl_low_o)));
  // R8: rise strobe is one cycle wide
  p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |=> !rise_stb_o);

endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
  import sclgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic [7:0] ccr_lo_i,
  input  logic [7:0] ccr_hi_i,
  input  logic       scl_line_i,
  output logic       scl_low_o,
  output logic       rise_stb_o,
  output logic       fall_stb_o
);

  logic [LEN_W-1:0] hi_len;
  logic [LEN_W-1:0] lo_len;
  logic             line_hi;

  sclgen_phase_calc u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ccr_lo_i (ccr_lo_i),
    .ccr_hi_i (ccr_hi_i),
    .hi_len_o (hi_len),
    .lo_len_o (lo_len)
  );

  sclgen_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (scl_line_i),
    .line_hi_o (line_hi)
  );

  sclgen_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .line_hi_i  (line_hi),
    .hi_len_i   (hi_len),
    .lo_len_i   (lo_len),
    .scl_low_o  (scl_low_o),
    .rise_stb_o (rise_stb_o),
    .fall_stb_o (fall_stb_o)
  );

  // R7: the line is only released, never pulled, while the synchronizer reads low
  p_low_ends_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_low_o) |-> !rise_stb_o);

endmodule

// File: tb/sclgen_top_tb_top.sv
module sclgen_top_tb_top;

  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_i = 1'b0;
  logic [7:0] ccr_lo_i = 8'd0;
  logic [7:0] ccr_hi_i = 8'd0;
  logic       hold = 1'b0;
  logic       scl_line;
  logic       scl_low_o, rise_stb_o, fall_stb_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_line = !scl_low_o && !hold;

  sclgen_top #(.SYNC_STAGES(SYNC)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .ccr_lo_i   (ccr_lo_i),
    .ccr_hi_i   (ccr_hi_i),
    .scl_line_i (scl_line),
    .scl_low_o  (scl_low_o),
    .rise_stb_o (rise_stb_o),
    .fall_stb_o (fall_stb_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_val(input int raw, input int mode);
    int fl;
    fl = (mode == 2) ? 1 : 4;
    return (raw < fl) ? fl : raw;
  endfunction

  function automatic int exp_high(input int raw, input int mode);
    return (mode == 2) ? 9 * eff_val(raw, mode) : eff_val(raw, mode);
  endfunction

  function automatic int exp_low(input int raw, input int mode);
    if (mode == 0) return eff_val(raw, mode);
    if (mode == 1) return 2 * eff_val(raw, mode);
    return 16 * eff_val(raw, mode);
  endfunction

  task automatic configure(input int raw, input int mode, input logic [1:0] spare);
    @(negedge clk);
    enable_i = 1'b0;
    ccr_lo_i = raw[7:0];
    ccr_hi_i = {mode != 0, mode == 2, spare, raw[11:8]};
    @(negedge clk);
    enable_i = 1'b1;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!rise_stb_o);
  endtask

  // At entry the current sample shows rise_stb_o.
  task automatic measure(input int eh, input int el, input string tag);
    int n;
    n = 1;
    @(negedge clk);
    chk(rise_stb_o, 0, {tag, " R8 rise width"});
    while (!fall_stb_o) begin
      n++;
      @(negedge clk);
    end
    chk(n, eh, {tag, " high length"});
    chk(scl_low_o, 1, {tag, " R8 fall marks low"});
    n = 0;
    while (scl_low_o) begin
      n++;
      @(negedge clk);
    end
    chk(n, el, {tag, " low length"});
  endtask

  task automatic stretch_test(input int k);
    int n;
    configure(5, 0, 2'b00);
    wait_rise();
    do @(negedge clk); while (!fall_stb_o);
    hold = 1'b1;
    while (scl_low_o) @(negedge clk);
    n = 0;
    if (k == 0) hold = 1'b0;
    while (!rise_stb_o) begin
      @(negedge clk);
      n++;
      if (n == k) hold = 1'b0;
    end
    hold = 1'b0;
    chk(n, k + SYNC + 1, $sformatf("R7 stretch k=%0d", k));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(scl_low_o, 0, "R1 reset scl_low");
    chk(rise_stb_o | fall_stb_o, 0, "R1 reset strobes");
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(scl_low_o | rise_stb_o | fall_stb_o, 0, "R1 disabled idle");
    end

    // Sweep small control values in all three modes (R2..R6).
    for (int mode = 0; mode < 3; mode++) begin
      for (int raw = 0; raw <= 12; raw++) begin
        string tg;
        tg = $sformatf("%s mode=%0d ccr=%0d",
                       (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4", mode, raw);
        if (raw < 4 && mode != 2) tg = {tg, " R5"};
        if (raw == 0 && mode == 2) tg = {tg, " R6"};
        configure(raw, mode, 2'b00);
        wait_rise();
        measure(exp_high(raw, mode), exp_low(raw, mode), tg);
      end
    end

    // R10: upper nibble placement, spare bits ignored.
    configure(12'h105, 0, 2'b11);
    wait_rise();
    measure(exp_high(12'h105, 0), exp_low(12'h105, 0), "R10 std ccr=0x105 spare=11");
    configure(12'h100, 2, 2'b10);
    wait_rise();
    measure(exp_high(12'h100, 2), exp_low(12'h100, 2), "R10 fast16:9 ccr=0x100");
    configure(12'h028, 0, 2'b01);
    wait_rise();
    measure(40, 40, "R10 R2 ccr=0x28");

    // R7: clock stretching by the slave.
    stretch_test(0);
    stretch_test(3);
    stretch_test(10);

    // R9: disable mid low phase, then re-enable.
    configure(6, 1, 2'b00);
    wait_rise();
    do @(negedge clk); while (!fall_stb_o);
    @(negedge clk);
    enable_i = 1'b0;
    @(negedge clk);
    chk(scl_low_o, 0, "R9 release after disable");
    repeat (5) begin
      @(negedge clk);
      chk(scl_low_o | rise_stb_o | fall_stb_o, 0, "R1 held disabled");
    end
    enable_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rise_stb_o && !fall_stb_o && n < 50);
    chk(rise_stb_o, 1, "R9 first strobe is rise");
    chk(n, 2, "R9 rise delay after enable");
    measure(6, 12, "R9 R3 after re-enable");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule